// File: doc/BRIEF.md
# Microcode Triad Store

This block holds microcode in groups of four consecutive addresses called triads. The first three addresses of a triad hold micro-operations (uops). The fourth address is an implicit no-operation slot with no storage behind it. Each triad also carries one sequence word, which tells the sequencer how execution continues after the triad. The lower part of the address space is read-only, and its contents come from a seeded function of the address. A small upper region, starting at a fixed triad boundary, is writable.

The block has two ports. The fetch port serves the sequencer: it takes one address per cycle and returns the uop at that address together with the sequence word of its triad. The access port reaches four arrays through a 2-bit selector, an address and data:

- a uop view of the whole address space;
- a sequence-word view of the whole address space;
- the writable sequence-word array;
- the writable uop array, which is written in address order and read back column by column.

Top module: `ustore_triad`

## Requirements
- R1: With default parameters, a fetch of an address a below 0x7C00 whose low two bits are not 3 returns uop (a*0x9E3779B1) XOR 0x5A5A0F0F and sequence word ((a>>2)+1)*0x85EBCA6B XOR 0xC3C31234, both modulo 2^32. The values appear in the cycle after the request, with fetch_vld high.
- R2: Any address whose low two bits are 3 reads as uop zero. This holds for the fetch port and for access selector 0 (uop view), in both the read-only and the writable regions.
- R3: Access selector 1 (sequence view) returns the same word for all four addresses of a triad. The next triad's word appears four addresses later.
- R4: A write with selector 3 at linear index i stores the uop of address 0x7C00+i. The fetch port and selector 0 then return it at that address.
- R5: A read with selector 3 is column-major. Entry t returns the first uop of writable triad t, entry 0x80+t the second and entry 0x100+t the third, for t from 0 to 0x7F. Entries from 0x180 upward read zero.
- R6: Selector 2 addresses 0x80 sequence words, index k serving the triad at 0x7C00+4k. Once written, the word is returned by the fetch port and by selector 1 for that triad, and by selector 2 at index k.
- R7: Some writes are illegal: a write with selector 0 or 1, a selector 3 write to a slot-3 index or to an index at or above 0x200, and a selector 2 write at or above 0x80. Such a write changes no stored value and raises acc_err for exactly the next cycle. A legal write leaves acc_err low.
- R8: Fetches and selector 0/1 reads at or above 0x7E00 return zero.
- R9: After reset, fetch_vld, acc_rvld and acc_err are low, and all writable uops and sequence words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | ADDR_W | Uop address to fetch |
| fetch_vld | output | 1 | Fetch result valid, one cycle after request |
| fetch_uop | output | UOP_W | Fetched uop |
| fetch_seq | output | SEQ_W | Sequence word of the fetched triad |
| acc_req | input | 1 | Array access request |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | Array selector: 0 uop view, 1 sequence view, 2 writable sequence, 3 writable uop |
| acc_addr | input | ADDR_W | Array address or index |
| acc_wdata | input | DW | Write data |
| acc_rvld | output | 1 | Read data valid, one cycle after a read |
| acc_rdata | output | DW | Read data |
| acc_err | output | 1 | One-cycle pulse after an illegal write |

## Verification
Fetches are run over offsets 0, 1 and 2 of several read-only triads and against the slot-3 addresses. This separates an offset or column decode error from a triad index error. The writable uop array is written at scattered linear indices, then read through the fetch port, the uop view and the column-major view. A mismatch among the three exposes a swapped column or triad mapping. Illegal writes are each followed by read-back of the slots they could have touched, and the boundaries 0x7BFF/0x7C00, 0x7DFF/0x7E00 and 0x17F/0x180 are tried on both sides.

// File: rtl/ustore_pkg.sv
package ustore_pkg;

   typedef enum logic [1:0] {
      ARR_UOP  = 2'd0,
      ARR_SEQ  = 2'd1,
      ARR_WSEQ = 2'd2,
      ARR_WUOP = 2'd3
   } arr_sel_e;

   localparam int SLOTS_PER_TRIAD = 4;
   localparam int UOPS_PER_TRIAD  = 3;

   // Read-only uop content as a function of the uop address.
   function automatic logic [31:0] rom_uop_word(input logic [31:0] a, input logic [31:0] seed);
      return (a * 32'h9E37_79B1) ^ seed;
   endfunction

   // Read-only sequence word as a function of the triad number.
   function automatic logic [31:0] rom_seq_word(input logic [31:0] t, input logic [31:0] seed);
      return ((t + 32'd1) * 32'h85EB_CA6B) ^ seed;
   endfunction

endpackage

// File: rtl/ustore_rom.sv
module ustore_rom
   import ustore_pkg::*;
#(
   parameter int          UOP_W    = 32,
   parameter int          SEQ_W    = 32,
   parameter int          ADDR_W   = 15,
   parameter logic [31:0] UOP_SEED = 32'h5A5A_0F0F,
   parameter logic [31:0] SEQ_SEED = 32'hC3C3_1234
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [UOP_W-1:0]  uop,
   output logic [SEQ_W-1:0]  seq
);

   always_comb begin
      if (addr[1:0] == 2'd3)
         uop = '0;
      else
         uop = UOP_W'(rom_uop_word(32'(addr), UOP_SEED));
      seq = SEQ_W'(rom_seq_word(32'(addr[ADDR_W-1:2]), SEQ_SEED));
   end

endmodule

// File: rtl/ustore_wuop.sv
module ustore_wuop
   import ustore_pkg::*;
#(
   parameter int UOP_W  = 32,
   parameter int TRIADS = 128,
   localparam int TW    = $clog2(TRIADS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [TW-1:0]    w_triad,
   input  logic [1:0]       w_col,
   input  logic [UOP_W-1:0] w_data,
   input  logic [TW-1:0]    ra_triad,
   input  logic [1:0]       ra_col,
   output logic [UOP_W-1:0] ra_data,
   input  logic [TW-1:0]    rb_triad,
   input  logic [1:0]       rb_col,
   output logic [UOP_W-1:0] rb_data
);

   logic [UOP_W-1:0] col_a [UOPS_PER_TRIAD];
   logic [UOP_W-1:0] col_b [UOPS_PER_TRIAD];

   for (genvar c = 0; c < UOPS_PER_TRIAD; c++) begin : g_col
      logic [UOP_W-1:0] mem [TRIADS];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < TRIADS; i++) mem[i] <= '0;
         end else if (we && w_col == 2'(c)) begin
            mem[w_triad] <= w_data;
         end
      end

      assign col_a[c] = mem[ra_triad];
      assign col_b[c] = mem[rb_triad];
   end

   // The slot-3 column has no storage and reads as zero.
   always_comb begin
      ra_data = '0;
      rb_data = '0;
      for (int c = 0; c < UOPS_PER_TRIAD; c++) begin
         if (ra_col == 2'(c)) ra_data = col_a[c];
         if (rb_col == 2'(c)) rb_data = col_b[c];
      end
   end

   // R7
   nop_slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (w_col != 2'd3));

endmodule

// File: rtl/ustore_wseq.sv
module ustore_wseq #(
   parameter int SEQ_W  = 32,
   parameter int TRIADS = 128,
   localparam int TW    = $clog2(TRIADS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [TW-1:0]    w_idx,
   input  logic [SEQ_W-1:0] w_data,
   input  logic [TW-1:0]    ra_idx,
   output logic [SEQ_W-1:0] ra_data,
   input  logic [TW-1:0]    rb_idx,
   output logic [SEQ_W-1:0] rb_data
);

   logic [SEQ_W-1:0] mem [TRIADS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < TRIADS; i++) mem[i] <= '0;
      end else if (we) begin
         mem[w_idx] <= w_data;
      end
   end

   assign ra_data = mem[ra_idx];
   assign rb_data = mem[rb_idx];

endmodule

// File: rtl/ustore_triad.sv
module ustore_triad
   import ustore_pkg::*;
#(
   parameter int          UOP_W     = 32,
   parameter int          SEQ_W     = 32,
   parameter int          ADDR_W    = 15,
   parameter int          RO_TRIADS = 32'h1F00,
   parameter int          RW_TRIADS = 128,
   parameter logic [31:0] UOP_SEED  = 32'h5A5A_0F0F,
   parameter logic [31:0] SEQ_SEED  = 32'hC3C3_1234,
   localparam int         DW        = (UOP_W > SEQ_W) ? UOP_W : SEQ_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_vld,
   output logic [UOP_W-1:0]  fetch_uop,
   output logic [SEQ_W-1:0]  fetch_seq,
   input  logic              acc_req,
   input  logic              acc_wr,
   input  logic [1:0]        acc_sel,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DW-1:0]     acc_wdata,
   output logic              acc_rvld,
   output logic [DW-1:0]     acc_rdata,
   output logic              acc_err
);

   localparam int TW = $clog2(RW_TRIADS);
   localparam int RW_BASE = RO_TRIADS * SLOTS_PER_TRIAD;
   localparam int RW_END  = RW_BASE + RW_TRIADS * SLOTS_PER_TRIAD;
   localparam logic [ADDR_W:0] RW_BASE_A  = (ADDR_W+1)'(RW_BASE);
   localparam logic [ADDR_W:0] RW_END_A   = (ADDR_W+1)'(RW_END);
   localparam logic [ADDR_W:0] WSEQ_LIM_A = (ADDR_W+1)'(RW_TRIADS);
   localparam logic [ADDR_W:0] WLIN_LIM_A = (ADDR_W+1)'(RW_TRIADS * SLOTS_PER_TRIAD);
   localparam logic [ADDR_W:0] WCOL_LIM_A = (ADDR_W+1)'(RW_TRIADS * UOPS_PER_TRIAD);

   // Elaboration-time parameter checks
   if (RW_END > (1 << ADDR_W)) begin : g_bad_space
      $error("address width too small for the triad regions");
   end
   if ((1 << TW) != RW_TRIADS || RW_TRIADS < 2) begin : g_bad_rw
      $error("writable triad count must be a power of two");
   end
   if (UOP_W < 1 || SEQ_W < 1) begin : g_bad_width
      $error("data widths must be positive");
   end

   logic [ADDR_W:0] fa_x, aa_x;
   assign fa_x = {1'b0, fetch_addr};
   assign aa_x = {1'b0, acc_addr};

   // Read-only content lookups
   logic [UOP_W-1:0] rom_f_uop, rom_a_uop;
   logic [SEQ_W-1:0] rom_f_seq, rom_a_seq;

   ustore_rom #(.UOP_W(UOP_W), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W),
                .UOP_SEED(UOP_SEED), .SEQ_SEED(SEQ_SEED)) u_rom_f (
      .addr(fetch_addr), .uop(rom_f_uop), .seq(rom_f_seq));

   ustore_rom #(.UOP_W(UOP_W), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W),
                .UOP_SEED(UOP_SEED), .SEQ_SEED(SEQ_SEED)) u_rom_a (
      .addr(acc_addr), .uop(rom_a_uop), .seq(rom_a_seq));

   // Writable storage
   logic              wu_we, ws_we;
   logic [TW-1:0]     wu_triad, ws_idx;
   logic [1:0]        wu_col;
   logic [TW-1:0]     f_triad, b_triad, sb_idx;
   logic [1:0]        b_col;
   logic [UOP_W-1:0]  wu_a_data, wu_b_data;
   logic [SEQ_W-1:0]  ws_a_data, ws_b_data;

   ustore_wuop #(.UOP_W(UOP_W), .TRIADS(RW_TRIADS)) u_wuop (
      .clk(clk), .rst_n(rst_n),
      .we(wu_we), .w_triad(wu_triad), .w_col(wu_col), .w_data(UOP_W'(acc_wdata)),
      .ra_triad(f_triad), .ra_col(fetch_addr[1:0]), .ra_data(wu_a_data),
      .rb_triad(b_triad), .rb_col(b_col), .rb_data(wu_b_data));

   ustore_wseq #(.SEQ_W(SEQ_W), .TRIADS(RW_TRIADS)) u_wseq (
      .clk(clk), .rst_n(rst_n),
      .we(ws_we), .w_idx(ws_idx), .w_data(SEQ_W'(acc_wdata)),
      .ra_idx(f_triad), .ra_data(ws_a_data),
      .rb_idx(sb_idx), .rb_data(ws_b_data));

   // Fetch path decode
   logic             f_in_ro, f_in_rw;
   logic [UOP_W-1:0] f_uop_n;
   logic [SEQ_W-1:0] f_seq_n;

   always_comb begin
      f_in_ro = fa_x < RW_BASE_A;
      f_in_rw = !f_in_ro && (fa_x < RW_END_A);
      f_triad = TW'((fa_x - RW_BASE_A) >> 2);
      if (f_in_ro) begin
         f_uop_n = rom_f_uop;
         f_seq_n = rom_f_seq;
      end else if (f_in_rw) begin
         f_uop_n = wu_a_data;
         f_seq_n = ws_a_data;
      end else begin
         f_uop_n = '0;
         f_seq_n = '0;
      end
   end

   // Access path decode
   logic          a_in_ro, a_in_rw, a_wr_ok;
   logic [DW-1:0] a_rdata_n;

   always_comb begin
      a_in_ro   = aa_x < RW_BASE_A;
      a_in_rw   = !a_in_ro && (aa_x < RW_END_A);
      b_triad   = TW'((aa_x - RW_BASE_A) >> 2);
      b_col     = acc_addr[1:0];
      sb_idx    = TW'((aa_x - RW_BASE_A) >> 2);
      wu_triad  = TW'(aa_x >> 2);
      wu_col    = acc_addr[1:0];
      ws_idx    = TW'(aa_x);
      a_wr_ok   = 1'b0;
      a_rdata_n = '0;
      case (arr_sel_e'(acc_sel))
         ARR_UOP: begin
            if (a_in_ro)      a_rdata_n = DW'(rom_a_uop);
            else if (a_in_rw) a_rdata_n = DW'(wu_b_data);
         end
         ARR_SEQ: begin
            if (a_in_ro)      a_rdata_n = DW'(rom_a_seq);
            else if (a_in_rw) a_rdata_n = DW'(ws_b_data);
         end
         ARR_WSEQ: begin
            sb_idx  = TW'(aa_x);
            a_wr_ok = aa_x < WSEQ_LIM_A;
            if (aa_x < WSEQ_LIM_A) a_rdata_n = DW'(ws_b_data);
         end
         ARR_WUOP: begin
            b_triad = TW'(aa_x);
            b_col   = 2'(aa_x >> TW);
            a_wr_ok = (aa_x < WLIN_LIM_A) && (acc_addr[1:0] != 2'd3);
            if (aa_x < WCOL_LIM_A) a_rdata_n = DW'(wu_b_data);
         end
         default: ;
      endcase
      wu_we = acc_req && acc_wr && a_wr_ok && (arr_sel_e'(acc_sel) == ARR_WUOP);
      ws_we = acc_req && acc_wr && a_wr_ok && (arr_sel_e'(acc_sel) == ARR_WSEQ);
   end

   // Output registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_vld <= 1'b0;
         fetch_uop <= '0;
         fetch_seq <= '0;
         acc_rvld  <= 1'b0;
         acc_rdata <= '0;
         acc_err   <= 1'b0;
      end else begin
         fetch_vld <= fetch_req;
         if (fetch_req) begin
            fetch_uop <= f_uop_n;
            fetch_seq <= f_seq_n;
         end
         acc_rvld <= acc_req && !acc_wr;
         if (acc_req && !acc_wr) acc_rdata <= a_rdata_n;
         acc_err <= acc_req && acc_wr && !a_wr_ok;
      end
   end

   // R7
   err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |-> $past(acc_req && acc_wr));

   // R9
   rvld_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rvld |-> $past(acc_req && !acc_wr));

   // R2
   nop_fetch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && fetch_addr[1:0] == 2'd3) |=> (fetch_uop == '0));

   // R8
   fetch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && fa_x >= RW_END_A) |=> (fetch_uop == '0 && fetch_seq == '0));

   // R1
   fetch_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |=> fetch_vld);

endmodule

// File: tb/tb_ustore_triad.sv
module tb_ustore_triad;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_req = 1'b0;
   logic [14:0] fetch_addr = '0;
   logic        fetch_vld;
   logic [31:0] fetch_uop, fetch_seq;
   logic        acc_req = 1'b0, acc_wr = 1'b0;
   logic [1:0]  acc_sel = '0;
   logic [14:0] acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic        acc_rvld;
   logic [31:0] acc_rdata;
   logic        acc_err;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ustore_triad dut (
      .clk(clk), .rst_n(rst_n),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_vld(fetch_vld),
      .fetch_uop(fetch_uop), .fetch_seq(fetch_seq),
      .acc_req(acc_req), .acc_wr(acc_wr), .acc_sel(acc_sel), .acc_addr(acc_addr),
      .acc_wdata(acc_wdata), .acc_rvld(acc_rvld), .acc_rdata(acc_rdata), .acc_err(acc_err));

   function automatic logic [31:0] exp_uop(input logic [14:0] a);
      if (a[1:0] == 2'd3) return 32'd0;
      return (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   function automatic logic [31:0] exp_seq(input logic [14:0] a);
      return ((32'(a >> 2) + 32'd1) * 32'h85EB_CA6B) ^ 32'hC3C3_1234;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_fetch(input logic [14:0] a, output logic [31:0] u, output logic [31:0] s, output logic v);
      @(negedge clk);
      fetch_req = 1'b1; fetch_addr = a;
      @(negedge clk);
      fetch_req = 1'b0;
      u = fetch_uop; s = fetch_seq; v = fetch_vld;
   endtask

   task automatic do_read(input logic [1:0] sel, input logic [14:0] a, output logic [31:0] d);
      @(negedge clk);
      acc_req = 1'b1; acc_wr = 1'b0; acc_sel = sel; acc_addr = a;
      @(negedge clk);
      acc_req = 1'b0;
      d = acc_rdata;
   endtask

   task automatic do_write(input logic [1:0] sel, input logic [14:0] a, input logic [31:0] d, output logic e);
      @(negedge clk);
      acc_req = 1'b1; acc_wr = 1'b1; acc_sel = sel; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_req = 1'b0; acc_wr = 1'b0;
      e = acc_err;
   endtask

   task automatic t_reset();
      logic [31:0] u, s; logic v;
      check("R9 fetch_vld", 32'(fetch_vld), 0);
      check("R9 acc_rvld", 32'(acc_rvld), 0);
      check("R9 acc_err", 32'(acc_err), 0);
      do_fetch(15'h7C01, u, s, v);
      check("R9 writable uop cleared", u, 0);
      check("R9 writable seq cleared", s, 0);
   endtask

   task automatic t_rom_fetch();
      logic [31:0] u, s; logic v;
      logic [14:0] list [6] = '{15'h0000, 15'h0001, 15'h0002, 15'h0012, 15'h1235, 15'h7BFE};
      foreach (list[i]) begin
         do_fetch(list[i], u, s, v);
         check("R1 fetch_vld", 32'(v), 1);
         check("R1 rom uop", u, exp_uop(list[i]));
         check("R1 rom seq", s, exp_seq(list[i]));
      end
   endtask

   task automatic t_nop();
      logic [31:0] u, s, d; logic v;
      do_fetch(15'h0003, u, s, v);
      check("R2 fetch nop uop", u, 0);
      check("R2 fetch nop seq", s, exp_seq(15'h0003));
      do_read(2'd0, 15'h0007, d);
      check("R2 uop view nop", d, 0);
      do_read(2'd0, 15'h7C03, d);
      check("R2 writable nop view", d, 0);
   endtask

   task automatic t_seq_view();
      logic [31:0] d;
      for (int i = 0; i < 4; i++) begin
         do_read(2'd1, 15'(32'h20 + i), d);
         check("R3 same word in triad", d, exp_seq(15'h0020));
      end
      do_read(2'd1, 15'h0024, d);
      check("R3 next triad word", d, exp_seq(15'h0024));
      do_read(2'd0, 15'h7BFF, d);
      check("R3 last ro slot nop", d, 0);
   endtask

   task automatic t_wuop();
      logic [31:0] u, s, d; logic v, e;
      logic [14:0] lin [5] = '{15'h000, 15'h001, 15'h002, 15'h004, 15'h1FE};
      foreach (lin[i]) begin
         do_write(2'd3, lin[i], 32'hA000_0000 + 32'(lin[i]), e);
         check("R4 legal write no err", 32'(e), 0);
      end
      foreach (lin[i]) begin
         do_fetch(15'h7C00 + lin[i], u, s, v);
         check("R4 fetch written uop", u, 32'hA000_0000 + 32'(lin[i]));
         do_read(2'd0, 15'h7C00 + lin[i], d);
         check("R4 uop view written", d, 32'hA000_0000 + 32'(lin[i]));
      end
   endtask

   task automatic t_colmajor();
      logic [31:0] d;
      do_read(2'd3, 15'h000, d); check("R5 col0 triad0", d, 32'hA000_0000);
      do_read(2'd3, 15'h080, d); check("R5 col1 triad0", d, 32'hA000_0001);
      do_read(2'd3, 15'h100, d); check("R5 col2 triad0", d, 32'hA000_0002);
      do_read(2'd3, 15'h001, d); check("R5 col0 triad1", d, 32'hA000_0004);
      do_read(2'd3, 15'h17F, d); check("R5 col2 triad7F", d, 32'hA000_01FE);
      do_read(2'd3, 15'h002, d); check("R5 col0 triad2 empty", d, 0);
      do_read(2'd3, 15'h180, d); check("R5 beyond columns", d, 0);
   endtask

   task automatic t_wseq();
      logic [31:0] u, s, d; logic v, e;
      do_write(2'd2, 15'h000, 32'h5EC0_0000, e); check("R6 write idx0 no err", 32'(e), 0);
      do_write(2'd2, 15'h07F, 32'h5EC0_007F, e); check("R6 write idx7F no err", 32'(e), 0);
      do_fetch(15'h7C01, u, s, v);
      check("R6 fetch seq triad0", s, 32'h5EC0_0000);
      check("R6 fetch uop triad0", u, 32'hA000_0001);
      do_read(2'd1, 15'h7DFD, d); check("R6 seq view last triad", d, 32'h5EC0_007F);
      do_read(2'd2, 15'h07F, d); check("R6 wseq read back", d, 32'h5EC0_007F);
      do_read(2'd2, 15'h080, d); check("R6 wseq out of range read", d, 0);
   endtask

   task automatic t_errors();
      logic [31:0] u, s, d; logic v, e;
      do_write(2'd0, 15'h0010, 32'hDEAD_0001, e); check("R7 ro uop write err", 32'(e), 1);
      check("R7 err one cycle", 32'(acc_err), 1);
      @(negedge clk); check("R7 err drops", 32'(acc_err), 0);
      do_read(2'd0, 15'h0010, d); check("R7 ro uop unchanged", d, exp_uop(15'h0010));
      do_write(2'd1, 15'h0010, 32'hDEAD_0002, e); check("R7 ro seq write err", 32'(e), 1);
      do_read(2'd1, 15'h0010, d); check("R7 ro seq unchanged", d, exp_seq(15'h0010));
      do_write(2'd3, 15'h003, 32'hDEAD_0003, e); check("R7 nop slot write err", 32'(e), 1);
      do_fetch(15'h7C03, u, s, v); check("R7 nop slot still zero", u, 0);
      do_fetch(15'h7C02, u, s, v); check("R7 neighbour unchanged", u, 32'hA000_0002);
      do_write(2'd3, 15'h200, 32'hDEAD_0004, e); check("R7 wuop range err", 32'(e), 1);
      do_read(2'd3, 15'h000, d); check("R7 wuop entry0 unchanged", d, 32'hA000_0000);
      do_write(2'd2, 15'h080, 32'hDEAD_0005, e); check("R7 wseq range err", 32'(e), 1);
      do_read(2'd2, 15'h000, d); check("R7 wseq entry0 unchanged", d, 32'h5EC0_0000);
   endtask

   task automatic t_range();
      logic [31:0] u, s, d; logic v;
      do_fetch(15'h7E00, u, s, v);
      check("R8 fetch 7E00 uop", u, 0); check("R8 fetch 7E00 seq", s, 0);
      do_fetch(15'h7FFE, u, s, v); check("R8 fetch 7FFE uop", u, 0);
      do_read(2'd1, 15'h7E04, d); check("R8 seq view beyond", d, 0);
      do_read(2'd0, 15'h7E01, d); check("R8 uop view beyond", d, 0);
      do_read(2'd0, 15'h7DFE, d); check("R8 last writable slot", d, 32'hA000_01FE);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rom_fetch();
      t_nop();
      t_seq_view();
      t_wuop();
      t_colmajor();
      t_wseq();
      t_errors();
      t_range();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule